// File: doc/BRIEF.md
# Key-Locked Indexed Configuration Port

This block is a byte-wide I/O slave that gives a host access to a small bank of configuration registers through two I/O addresses. One address holds an index, and the other is a data window onto the register the index selects. Writes to the index address load the index. Reads and writes at the data address then reach whichever register that index names. The index keeps its value, so a run of data accesses all land on the same register.

A guard register sits in the indexed space. The register bank stays sealed until the guard receives one magic byte. Any other byte written to the guard seals the bank again. While the bank is sealed, data-port reads return all ones and data-port writes are dropped. The single exception is a write of the magic byte to the guard. Downstream logic, such as an interrupt steering unit, reads the bank contents continuously on a flat output bus.

The data path is combinational on reads: `io_rdata` is valid while `io_rd` is high. Writes take effect on the clock edge at which `io_wr` is sampled.

Top module: `keyed_cfg_port`

## Requirements
- R1: After reset the bank is sealed, the index is 0x00, every configuration register is 0x00 and `cfg_o` is all zeros.
- R2: A data-port write of 0xC5 while the index is 0x03 unseals the bank, whether it was sealed or not.
- R3: A data-port write of any value other than 0xC5 while the index is 0x03 seals the bank.
- R4: While sealed, a data-port write to any index other than 0x03 changes no configuration register.
- R5: While sealed, a data-port read returns 0xFF.
- R6: A write to address 0x22 loads the index on that edge, sealed or not. A read of 0x22 returns the current index.
- R7: The index is unchanged by data-port reads and writes, so consecutive data accesses reach the same register.
- R8: While unsealed, a data-port write to index 0x42, 0x43 or 0x44 stores the byte on that edge. The next data read returns it, and `cfg_o` carries register 0x42+k in bits 8k+7:8k.
- R9: While unsealed, a data-port read of any index outside 0x42..0x44 (including 0x03) returns 0xFF and changes nothing.
- R10: Accesses to addresses other than 0x22 and 0x23 change no state. `io_rdata` is 0x00 whenever `io_rd` is low or the address is not one of the two ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| io_addr | input | 8 | I/O address |
| io_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, combinational while `io_rd` is high |
| cfg_o | output | 24 | Configuration bank contents, register 0x42 in the low byte |

## Verification
Every cycle, the assertions check the seal transitions on guard writes, the frozen bank under sealed writes, the 0xFF return on sealed reads, and the index loading and holding. Only the bench scenarios can show that the stored bytes are the right ones and read back through the data window. The same holds for unimplemented indices reading 0xFF, stray addresses being ignored, and long random mixes of seal, unseal and access sequences matching a reference model.

// File: rtl/kcp_pkg.sv
package kcp_pkg;
  typedef enum logic [1:0] {
    PSEL_NONE  = 2'd0,
    PSEL_INDEX = 2'd1,
    PSEL_DATA  = 2'd2
  } port_sel_e;

  function automatic port_sel_e decode_port(input logic [7:0] addr,
                                            input logic [7:0] base);
    if (addr == base)              return PSEL_INDEX;
    else if (addr == base + 8'd1)  return PSEL_DATA;
    else                           return PSEL_NONE;
  endfunction
endpackage

// File: rtl/kcp_rst_sync.sv
module kcp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/kcp_index.sv
module kcp_index #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] idx_q
);
  logic [DW-1:0] idx_d;

  always_comb begin
    idx_d = idx_q;
    if (load) idx_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end
endmodule

// File: rtl/kcp_guard.sv
module kcp_guard #(
  parameter int          DW       = 8,
  parameter logic [7:0]  GUARD_IX = 8'h03,
  parameter logic [7:0]  KEY      = 8'hC5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          data_we,
  input  logic [DW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic          unlocked_q
);
  logic guard_hit;
  logic unlocked_d;

  assign guard_hit = data_we && (idx == GUARD_IX);

  always_comb begin
    unlocked_d = unlocked_q;
    if (guard_hit) unlocked_d = (wdata == KEY);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) unlocked_q <= 1'b0;
    else        unlocked_q <= unlocked_d;
  end
endmodule

// File: rtl/kcp_bank.sv
module kcp_bank #(
  parameter int          DW      = 8,
  parameter int          NREGS   = 3,
  parameter logic [7:0]  BASE_IX = 8'h42,
  parameter logic [7:0]  MISS_RD = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DW-1:0]     idx,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rd_val,
  output logic [NREGS*DW-1:0] bank_o
);
  logic [DW-1:0] reg_q [NREGS];
  logic [NREGS-1:0] hit;

  for (genvar k = 0; k < NREGS; k++) begin : g_reg
    logic [DW-1:0] reg_d;
    assign hit[k] = (idx == BASE_IX + DW'(k));

    always_comb begin
      reg_d = reg_q[k];
      if (wr_en && hit[k]) reg_d = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) reg_q[k] <= '0;
      else        reg_q[k] <= reg_d;
    end

    assign bank_o[k*DW +: DW] = reg_q[k];
  end

  always_comb begin
    rd_val = MISS_RD;
    for (int k = 0; k < NREGS; k++) begin
      if (hit[k]) rd_val = reg_q[k];
    end
  end
endmodule

// File: rtl/keyed_cfg_port.sv
module keyed_cfg_port #(
  parameter logic [7:0] PORT_BASE = 8'h22,
  parameter logic [7:0] GUARD_IX  = 8'h03,
  parameter logic [7:0] KEY       = 8'hC5,
  parameter logic [7:0] BASE_IX   = 8'h42,
  parameter int         NREGS     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  output logic [NREGS*8-1:0] cfg_o
);
  import kcp_pkg::*;
  localparam int DW = 8;
  localparam logic [7:0] MISS_RD = 8'hFF;

  logic      rst_sync_n;
  port_sel_e psel;
  logic      idx_we, data_we, bank_we;
  logic [DW-1:0] idx_q, bank_rd;
  logic      unlocked_q;

  kcp_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  assign psel    = decode_port(io_addr, PORT_BASE);
  assign idx_we  = io_wr && (psel == PSEL_INDEX);
  assign data_we = io_wr && (psel == PSEL_DATA);
  assign bank_we = data_we && unlocked_q;

  kcp_index #(.DW(DW)) u_index (
    .clk(clk), .rst_n(rst_sync_n), .load(idx_we), .wdata(io_wdata), .idx_q(idx_q)
  );

  kcp_guard #(.DW(DW), .GUARD_IX(GUARD_IX), .KEY(KEY)) u_guard (
    .clk(clk), .rst_n(rst_sync_n), .data_we(data_we), .idx(idx_q),
    .wdata(io_wdata), .unlocked_q(unlocked_q)
  );

  kcp_bank #(.DW(DW), .NREGS(NREGS), .BASE_IX(BASE_IX), .MISS_RD(MISS_RD)) u_bank (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(bank_we), .idx(idx_q),
    .wdata(io_wdata), .rd_val(bank_rd), .bank_o(cfg_o)
  );

  always_comb begin
    io_rdata = '0;
    if (io_rd) begin
      unique case (psel)
        PSEL_INDEX: io_rdata = idx_q;
        PSEL_DATA:  io_rdata = unlocked_q ? bank_rd : MISS_RD;
        default:    io_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/kcp_chk.sv
module kcp_chk #(
  parameter logic [7:0] PORT_BASE = 8'h22,
  parameter logic [7:0] GUARD_IX  = 8'h03,
  parameter logic [7:0] KEY       = 8'hC5,
  parameter int         NREGS     = 3
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic [7:0]        io_addr,
  input logic              io_wr,
  input logic              io_rd,
  input logic [7:0]        io_wdata,
  input logic [7:0]        io_rdata,
  input logic [NREGS*8-1:0] cfg_o,
  input logic [7:0]        idx_q,
  input logic              unlocked_q
);
  logic at_idx, at_data;
  assign at_idx  = (io_addr == PORT_BASE);
  assign at_data = (io_addr == PORT_BASE + 8'd1);

  // R2
  key_open_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (io_wr && at_data && idx_q == GUARD_IX && io_wdata == KEY) |=> unlocked_q);

  // R3
  relock_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (io_wr && at_data && idx_q == GUARD_IX && io_wdata != KEY) |=> !unlocked_q);

  // R4
  sealed_write_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (io_wr && at_data && !unlocked_q) |=> $stable(cfg_o));

  // R5
  sealed_read_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (io_rd && at_data && !unlocked_q) |-> io_rdata == 8'hFF);

  // R6
  idx_load_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (io_wr && at_idx) |=> idx_q == $past(io_wdata));

  // R7
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(io_wr && at_idx) |=> $stable(idx_q));
endmodule

bind keyed_cfg_port kcp_chk #(
  .PORT_BASE(PORT_BASE), .GUARD_IX(GUARD_IX), .KEY(KEY), .NREGS(NREGS)
) chk_i (
  .clk(clk), .rst_sync_n(rst_sync_n), .io_addr(io_addr), .io_wr(io_wr),
  .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata), .cfg_o(cfg_o),
  .idx_q(idx_q), .unlocked_q(unlocked_q)
);

// File: tb/keyed_cfg_port_tb_top.sv
module keyed_cfg_port_tb_top;
  localparam logic [7:0] IXP = 8'h22;
  localparam logic [7:0] DTP = 8'h23;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  io_addr = '0;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic [23:0] cfg_o;

  int vectors = 0;
  int errors  = 0;

  logic [7:0] m_idx;
  logic       m_open;
  logic [7:0] m_reg [3];

  always #4 clk = ~clk;

  keyed_cfg_port dut_i (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .cfg_o(cfg_o)
  );

  function automatic logic [7:0] exp_read(input logic [7:0] a);
    if (a == IXP) return m_idx;
    if (a != DTP) return 8'h00;
    if (!m_open)  return 8'hFF;
    if (m_idx >= 8'h42 && m_idx <= 8'h44) return m_reg[m_idx - 8'h42];
    return 8'hFF;
  endfunction

  function automatic logic [23:0] exp_bank();
    return {m_reg[2], m_reg[1], m_reg[0]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_write(input logic [7:0] a, input logic [7:0] d);
    if (a == IXP) m_idx = d;
    else if (a == DTP) begin
      if (m_idx == 8'h03) m_open = (d == 8'hC5);
      else if (m_open && m_idx >= 8'h42 && m_idx <= 8'h44) m_reg[m_idx - 8'h42] = d;
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] d, input string req);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
    model_write(a, d);
    check(req, cfg_o, exp_bank());
  endtask

  task automatic do_read(input logic [7:0] a, input string req);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    #1;
    check(req, io_rdata, exp_read(a));
    @(negedge clk);
    io_rd = 1'b0;
    #1;
    check("R10 idle rdata", io_rdata, 8'h00);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin : main
    int seed;
    seed = 32'h5EED_1234;
    void'($urandom(seed));
    m_idx = 8'h00; m_open = 1'b0;
    for (int k = 0; k < 3; k++) m_reg[k] = 8'h00;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 cfg reset", cfg_o, 24'h0);
    do_read(IXP, "R1 index reset");
    do_read(DTP, "R1 sealed after reset");

    // R4 R5 sealed access
    do_write(IXP, 8'h42, "R6 index load");
    do_write(DTP, 8'hA5, "R4 sealed write dropped");
    do_read(DTP, "R5 sealed read FF");

    // R2 unseal, R8 write and read back
    do_write(IXP, 8'h03, "R6 index to guard");
    do_write(DTP, 8'hC5, "R2 key");
    do_read(DTP, "R9 guard reads FF");
    do_write(IXP, 8'h43, "R6 index 43");
    do_read(IXP, "R6 index readback");
    do_write(DTP, 8'h3C, "R8 write 43");
    do_read(DTP, "R8 readback 43");
    do_write(DTP, 8'h5A, "R7 second write same reg");
    do_read(DTP, "R7 same reg");
    do_write(IXP, 8'h44, "R6 index 44");
    do_write(DTP, 8'h0F, "R8 write 44");
    do_write(IXP, 8'h45, "R6 index 45");
    do_write(DTP, 8'h77, "R9 unimplemented write");
    do_read(DTP, "R9 unimplemented read");

    // R10 stray addresses
    do_write(8'h24, 8'h99, "R10 stray write");
    do_read(8'h21, "R10 stray read");
    do_read(IXP, "R10 index unchanged");

    // R3 relock, R2 key while already open
    do_write(IXP, 8'h03, "R6 guard");
    do_write(DTP, 8'hC5, "R2 key while open");
    do_write(DTP, 8'hC4, "R3 relock");
    do_write(IXP, 8'h44, "R6 index 44");
    do_write(DTP, 8'hEE, "R4 sealed write");
    do_read(DTP, "R5 sealed read");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [7:0] a, d;
      int sel;
      sel = $urandom_range(0, 9);
      a = (sel < 4) ? IXP : (sel < 9) ? DTP : 8'($urandom);
      d = 8'($urandom);
      if (a == IXP) begin
        case ($urandom_range(0, 4))
          0: d = 8'h03;
          1: d = 8'h42;
          2: d = 8'h43;
          3: d = 8'h44;
          default: ;
        endcase
      end else if ($urandom_range(0, 2) == 0) d = 8'hC5;
      if ($urandom_range(0, 1) == 0) do_write(a, d, "R8 random write");
      else                           do_read(a, "R9 random read");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule